// File: doc/BRIEF.md
# APB Requester Transfer Sequencer

This block sits between a simple local command port and an APB4 bus. The local side offers a command with a valid/ready handshake: an address, a direction bit, write data, a byte-lane strobe and a protection code. The block turns each accepted command into one bus transfer. It drives a Setup cycle and then one or more Access cycles. Every request-side bus signal stays frozen while the completer holds PREADY low.

When a transfer finishes, the local side receives a one-cycle done pulse. The pulse carries the read data and the error flag that were sampled at the completing edge. A new command can be accepted in the completion cycle itself. The next transfer then goes straight to Setup without dropping the select, so a stream of commands keeps PSEL high from the first Setup to the last Access. On reads the strobe is always driven to zero, whatever the command carried.

Top module: `apbq_requester`

## Requirements
- R1: While reset is asserted, psel, penable and done_valid are 0 and cmd_ready is 1.
- R2: In the cycle after a command is accepted, psel=1 and penable=0 (Setup). paddr, pwrite, pwdata and pprot equal the command's fields, and pstrb equals cmd_strb for a write. These values do not change into the following cycle.
- R3: The cycle after a Setup cycle is an Access cycle (psel=1, penable=1).
- R4: A transfer completes on the rising edge at which psel, penable and pready are all 1, so the shortest transfer is two cycles. If no command is accepted in that cycle, psel and penable are both 0 in the next cycle.
- R5: During an Access cycle with pready=0, the next cycle is again an Access cycle, and paddr, pwrite, pwdata, pstrb and pprot hold their values.
- R6: pwrite is 1 for a write command (cmd_write=1) and 0 for a read. Whenever psel=1 and pwrite=0, pstrb is all zeros.
- R7: pready is ignored while penable=0. Its value in Idle or Setup cycles changes neither the phase sequence nor the done output.
- R8: A command accepted in a completion cycle starts Setup in the next cycle: psel stays 1, penable is 0, and the bus carries the new command's fields.
- R9: done_valid is 1 for exactly one cycle: the cycle after each completing edge. done_rdata and done_err then equal the prdata and pslverr sampled at that edge.
- R10: cmd_ready is 1 exactly when the block is idle (psel=0) or in a completion cycle (penable=1 and pready=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The offered command is taken at this edge |
| cmd_addr | input | AW | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DW | Write data |
| cmd_strb | input | DW/8 | Byte-lane strobe; bit n covers data bits 8n+7..8n |
| cmd_prot | input | PW | Protection code passed to the bus |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | DW | Read data captured at completion |
| done_err | output | 1 | Error flag captured at completion |
| psel | output | 1 | Bus select |
| penable | output | 1 | Access phase enable |
| paddr | output | AW | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DW | Bus write data |
| pstrb | output | DW/8 | Bus write strobe |
| pprot | output | PW | Bus protection code |
| pready | input | 1 | Completer ready |
| prdata | input | DW | Completer read data |
| pslverr | input | 1 | Completer error |

## Verification
The embedded properties watch several rules on every cycle. Setup is always followed by Access, wait cycles repeat Access with every request field frozen, the select is released or kept according to whether a command was taken, the strobe is zero on reads, and the done pulse never lasts two cycles. Other rules can only be shown by the bench's scenarios. These are that each bus transfer carries exactly the fields of the command that caused it, that the returned data and error match what the completer model drove, and that toggling pready during Idle and Setup cycles does not disturb the sequence. The scenarios cover zero-wait and randomly stalled completers, back-to-back chains, idle gaps and a spread of strobe patterns.

// File: rtl/apbq_pkg.sv
package apbq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;

endpackage

// File: rtl/apbq_seq.sv
module apbq_seq
    import apbq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic pready,
    output logic cmd_ready,
    output logic accept,
    output logic complete,
    output logic psel,
    output logic penable
);

    typedef struct packed {
        phase_e ph;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        complete  = (s_q.ph == PH_ACCESS) && pready;
        cmd_ready = (s_q.ph == PH_IDLE) || complete;
        accept    = cmd_valid && cmd_ready;
        case (s_q.ph)
            PH_IDLE:   if (accept) s_d.ph = PH_SETUP;
            PH_SETUP:  s_d.ph = PH_ACCESS;
            PH_ACCESS: if (pready) s_d.ph = accept ? PH_SETUP : PH_IDLE;
            default:   s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE};
        else        s_q <= s_d;
    end

    assign psel    = (s_q.ph != PH_IDLE);
    assign penable = (s_q.ph == PH_ACCESS);

    // R3
    setup_to_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (psel && penable));

    // R5
    wait_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |=> (psel && penable));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && !accept) |=> (!psel && !penable));

    // R8
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && accept) |=> (psel && !penable));

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |-> !cmd_ready);

endmodule

// File: rtl/apbq_hold.sv
module apbq_hold #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int PW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   cmd_addr,
    input  logic            cmd_write,
    input  logic [DW-1:0]   cmd_wdata,
    input  logic [DW/8-1:0] cmd_strb,
    input  logic [PW-1:0]   cmd_prot,
    input  logic            psel,
    input  logic            penable,
    input  logic            pready,
    output logic [AW-1:0]   paddr,
    output logic            pwrite,
    output logic [DW-1:0]   pwdata,
    output logic [DW/8-1:0] pstrb,
    output logic [PW-1:0]   pprot
);

    localparam int SW = DW / 8;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          write;
        logic [DW-1:0] wdata;
        logic [SW-1:0] strb;
        logic [PW-1:0] prot;
    } req_t;

    req_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.addr  = cmd_addr;
            r_d.write = cmd_write;
            r_d.wdata = cmd_wdata;
            r_d.prot  = cmd_prot;
            for (int i = 0; i < SW; i++) begin
                r_d.strb[i] = cmd_strb[i] && cmd_write;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign paddr  = r_q.addr;
    assign pwrite = r_q.write;
    assign pwdata = r_q.wdata;
    assign pstrb  = r_q.strb;
    assign pprot  = r_q.prot;

    // R5
    wait_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |=> ($stable(paddr) && $stable(pwrite) &&
            $stable(pwdata) && $stable(pstrb) && $stable(pprot)));

    // R2
    setup_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> ($stable(paddr) && $stable(pwrite) &&
            $stable(pwdata) && $stable(pstrb) && $stable(pprot)));

    // R6
    read_strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite) |-> (pstrb == '0));

endmodule

// File: rtl/apbq_resp.sv
module apbq_resp #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          complete,
    input  logic [DW-1:0] prdata,
    input  logic          pslverr,
    output logic          done_valid,
    output logic [DW-1:0] done_rdata,
    output logic          done_err
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] rdata;
        logic          err;
    } rsp_t;

    rsp_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.valid = complete;
        if (complete) begin
            p_d.rdata = prdata;
            p_d.err   = pslverr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign done_valid = p_q.valid;
    assign done_rdata = p_q.rdata;
    assign done_err   = p_q.err;

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R9
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (done_valid && done_rdata == $past(prdata) && done_err == $past(pslverr)));

endmodule

// File: rtl/apbq_requester.sv
module apbq_requester #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int PW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [AW-1:0]   cmd_addr,
    input  logic            cmd_write,
    input  logic [DW-1:0]   cmd_wdata,
    input  logic [DW/8-1:0] cmd_strb,
    input  logic [PW-1:0]   cmd_prot,
    output logic            done_valid,
    output logic [DW-1:0]   done_rdata,
    output logic            done_err,
    output logic            psel,
    output logic            penable,
    output logic [AW-1:0]   paddr,
    output logic            pwrite,
    output logic [DW-1:0]   pwdata,
    output logic [DW/8-1:0] pstrb,
    output logic [PW-1:0]   pprot,
    input  logic            pready,
    input  logic [DW-1:0]   prdata,
    input  logic            pslverr
);

    logic accept;
    logic complete;

    apbq_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .pready    (pready),
        .cmd_ready (cmd_ready),
        .accept    (accept),
        .complete  (complete),
        .psel      (psel),
        .penable   (penable)
    );

    apbq_hold #(.AW(AW), .DW(DW), .PW(PW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .cmd_addr  (cmd_addr),
        .cmd_write (cmd_write),
        .cmd_wdata (cmd_wdata),
        .cmd_strb  (cmd_strb),
        .cmd_prot  (cmd_prot),
        .psel      (psel),
        .penable   (penable),
        .pready    (pready),
        .paddr     (paddr),
        .pwrite    (pwrite),
        .pwdata    (pwdata),
        .pstrb     (pstrb),
        .pprot     (pprot)
    );

    apbq_resp #(.DW(DW)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .complete   (complete),
        .prdata     (prdata),
        .pslverr    (pslverr),
        .done_valid (done_valid),
        .done_rdata (done_rdata),
        .done_err   (done_err)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!psel && !penable && !done_valid && cmd_ready));

endmodule

// File: tb/sim_apbq_requester.sv
module sim_apbq_requester;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [3:0]  cmd_strb = '0;
    logic [2:0]  cmd_prot = '0;
    logic        done_valid;
    logic [31:0] done_rdata;
    logic        done_err;
    logic        psel, penable, pwrite;
    logic [31:0] paddr, pwdata;
    logic [3:0]  pstrb;
    logic [2:0]  pprot;
    logic        pready = 1'b0;
    logic [31:0] prdata = '0;
    logic        pslverr = 1'b0;

    always #4 clk = ~clk;

    apbq_requester u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
        .cmd_strb(cmd_strb), .cmd_prot(cmd_prot),
        .done_valid(done_valid), .done_rdata(done_rdata), .done_err(done_err),
        .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
        .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot),
        .pready(pready), .prdata(prdata), .pslverr(pslverr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        w;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [2:0]  prot;
    } bus_item_t;

    typedef struct packed {
        logic [31:0] rdata;
        logic        err;
    } rsp_item_t;

    bus_item_t exp_q[$];
    rsp_item_t rsp_q[$];

    int checks = 0;
    int errors = 0;
    int max_wait = 0;
    int wait_left = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_of(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    function automatic logic err_of(input logic [31:0] a);
        return a[15:12] == 4'hE;
    endfunction

    task automatic send(input logic [31:0] a, input logic w, input logic [31:0] d,
                        input logic [3:0] s, input logic [2:0] p);
        bit acc;
        bus_item_t it;
        cmd_addr  = a;
        cmd_write = w;
        cmd_wdata = d;
        cmd_strb  = s;
        cmd_prot  = p;
        cmd_valid = 1'b1;
        acc = 1'b0;
        while (!acc) begin
            @(negedge clk);
            #2;
            acc = cmd_ready;
            @(posedge clk);
        end
        it.addr = a; it.w = w; it.data = d; it.strb = w ? s : 4'h0; it.prot = p;
        exp_q.push_back(it);
        #1;
        cmd_valid = 1'b0;
    endtask

    // Monitor and completer model
    initial begin
        bit prev_setup, prev_wait, prev_complete, prev_accept;
        bus_item_t saved;
        prev_setup = 0; prev_wait = 0; prev_complete = 0; prev_accept = 0;
        saved = '0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (rsp_q.size() != 0) begin
                rsp_item_t r;
                r = rsp_q.pop_front();
                chk(done_valid == 1'b1, "R9 done pulse", {63'd0, done_valid}, 64'd1);
                chk(done_rdata == r.rdata, "R9 done_rdata", {32'd0, done_rdata}, {32'd0, r.rdata});
                chk(done_err == r.err, "R9 done_err", {63'd0, done_err}, {63'd0, r.err});
            end else begin
                // R7: pready toggled in idle/setup must never produce a done pulse
                chk(done_valid == 1'b0, "R9/R7 no spurious done", {63'd0, done_valid}, 64'd0);
            end
            if (prev_setup)
                chk(psel && penable, "R3 access after setup", {62'd0, psel, penable}, 64'd3);
            if (prev_wait) begin
                chk(psel && penable, "R5 access repeats", {62'd0, psel, penable}, 64'd3);
                chk({paddr, pwrite, pwdata, pstrb, pprot} ==
                    {saved.addr, saved.w, saved.data, saved.strb, saved.prot},
                    "R5 fields stable", {paddr, pwdata}, {saved.addr, saved.data});
            end
            if (prev_complete && !prev_accept)
                chk(!psel && !penable, "R4 release", {62'd0, psel, penable}, 64'd0);
            if (prev_complete && prev_accept)
                chk(psel && !penable, "R8 chained setup", {62'd0, psel, penable}, 64'd2);
            if (psel && !penable) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 setup without command", {32'd0, paddr}, 64'd0);
                end else begin
                    chk({paddr, pwrite, pwdata, pstrb, pprot} ==
                        {exp_q[0].addr, exp_q[0].w, exp_q[0].data, exp_q[0].strb, exp_q[0].prot},
                        "R2 setup fields", {paddr, pwdata}, {exp_q[0].addr, exp_q[0].data});
                end
                wait_left = (max_wait == 0) ? 0 : int'($urandom % (max_wait + 1));
            end
            if (psel && !pwrite)
                chk(pstrb == 4'h0, "R6 read strobe zero", {60'd0, pstrb}, 64'd0);
            // completer drives its inputs for this cycle
            if (psel && penable) begin
                if (wait_left > 0) begin
                    pready = 1'b0;
                    wait_left--;
                end else begin
                    pready = 1'b1;
                end
                prdata  = rd_of(paddr);
                pslverr = err_of(paddr);
            end else begin
                pready  = 1'($urandom % 2);   // R7: arbitrary while penable low
                prdata  = $urandom;
                pslverr = 1'($urandom % 2);
            end
            #1;
            chk(cmd_ready == (!psel || (penable && pready)), "R10 cmd_ready window",
                {63'd0, cmd_ready}, {63'd0, (!psel || (penable && pready))});
            prev_setup    = psel && !penable;
            prev_wait     = psel && penable && !pready;
            prev_complete = psel && penable && pready;
            prev_accept   = cmd_valid && cmd_ready;
            saved = '{addr: paddr, w: pwrite, data: pwdata, strb: pstrb, prot: pprot};
            if (prev_complete) begin
                rsp_item_t r;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 completion without command", {32'd0, paddr}, 64'd0);
                end else begin
                    bus_item_t e;
                    e = exp_q.pop_front();
                    chk({paddr, pwrite, pwdata, pstrb, pprot} == {e.addr, e.w, e.data, e.strb, e.prot},
                        "R4/R6 completed transfer fields", {paddr, pwdata}, {e.addr, e.data});
                end
                r.rdata = prdata;
                r.err   = pslverr;
                rsp_q.push_back(r);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(!psel && !penable && !done_valid, "R1 reset outputs",
            {61'd0, psel, penable, done_valid}, 64'd0);
        chk(cmd_ready == 1'b1, "R1 reset cmd_ready", {63'd0, cmd_ready}, 64'd1);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        // zero-wait completer: strobe patterns, reads, chained
        max_wait = 0;
        send(32'h0000_1000, 1'b1, 32'hDEAD_BEEF, 4'b1111, 3'd0);
        send(32'h0000_1004, 1'b1, 32'h0102_0304, 4'b0001, 3'd1);
        send(32'h0000_1008, 1'b1, 32'hA0B0_C0D0, 4'b0011, 3'd2);
        send(32'h0000_100C, 1'b1, 32'h5566_7788, 4'b1100, 3'd3);
        send(32'h0000_1010, 1'b0, 32'hFFFF_FFFF, 4'b1111, 3'd4);  // R6 read with strobe requested
        send(32'h0000_E014, 1'b0, 32'h0, 4'b0000, 3'd5);          // error address
        repeat (4) @(posedge clk);
        #1;
        // stalled completer
        max_wait = 3;
        send(32'h0000_2000, 1'b1, 32'h1111_2222, 4'b0110, 3'd6);
        send(32'h0000_2004, 1'b0, 32'h0, 4'b1010, 3'd7);
        send(32'h0000_E008, 1'b1, 32'h3333_4444, 4'b0000, 3'd0);
        repeat (5) @(posedge clk);
        #1;
        // random mix with gaps
        for (int i = 0; i < 60; i++) begin
            max_wait = int'($urandom % 5);
            send($urandom & 32'h0000_FFFC, 1'($urandom % 2), $urandom, 4'($urandom), 3'($urandom));
            if ($urandom % 4 == 0) begin
                repeat (int'($urandom % 3) + 1) @(posedge clk);
                #1;
            end
        end
        repeat (20) @(posedge clk);
        chk(exp_q.size() == 0, "R4 all transfers completed", 64'(exp_q.size()), 64'd0);
        chk(!psel && !penable, "R4 idle at end", {62'd0, psel, penable}, 64'd0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule